// File: doc/BRIEF.md
# Tearing Effect Sync Decoder

This block sits between a display panel's tearing-effect output and the engine that pushes pixels to the panel. The panel drives one pin that carries both its line pulses and its frame pulses. The block separates the two by the length of each active run, measured in ticks of a qualifying enable. It keeps a count of lines since the last frame pulse and issues a one-cycle start trigger to the transfer engine.

The trigger source is chosen by a 2-bit mode. The internal mode fires as soon as a transfer is enabled. The frame mode fires on each frame pulse. The line mode fires when a line or frame pulse brings the line count to a programmed target. After one trigger the block waits until the engine reports frame done, or until the enable drops, before it issues another. A configuration check flags pulse-width settings from which the two pulse kinds could not be told apart.

Top module: `te_sync_decoder`

## Requirements
- R1: After reset `start_trig` is 0 and `cur_line` is 0, and `cfg_err` is 0 while `trig_mode` is 0.
- R2: With `trig_mode` 0 or 3 (internal), `start_trig` pulses for one cycle in the first cycle after `xfer_en` is seen high, which is one clock after it rises.
- R3: An active run of `te_in` lasting at least `vs_width` ticks counts as a frame pulse. A run of at least `hs_width` ticks that is not a frame pulse counts as a line pulse. Shorter runs are ignored. A pulse is classified three clocks after `te_in` leaves the active level.
- R4: A frame pulse clears `cur_line` to 0. Each line pulse increments it, saturating at 2047. `cur_line` takes its new value four clocks after the pulse ends.
- R5: `vs_pol` and `hs_pol` set the active level of the frame and line pulses: 1 is high and 0 is low. A run at the inactive level is never classified.
- R6: With `trig_mode` 1 (frame), `start_trig` pulses four clocks after the end of a frame pulse. Line pulses never fire it.
- R7: With `trig_mode` 2 (line), `start_trig` pulses five clocks after the end of the pulse that updates `cur_line` to `target_line` (a frame pulse when the target is 0). A count that already equals the target when `xfer_en` rises does not fire it.
- R8: Only one trigger is issued while `xfer_en` stays high. `frame_done` or a low `xfer_en` re-arms it. In internal mode, with `xfer_en` held high, the next trigger comes two clocks after the `frame_done` cycle.
- R9: In modes 1 and 2, `cfg_err` is 1 when `hs_width` is below 2, when `vs_width` is below 4 (mode 1) or below 2 (mode 2), or when the two widths are equal. While `cfg_err` is set, modes 1 and 2 issue no trigger. In modes 0 and 3, `cfg_err` is 0.
- R10: No trigger is issued while `xfer_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Enable that advances the pulse-width counter |
| te_in | input | 1 | Raw tearing-effect pin, may be asynchronous |
| trig_mode | input | 2 | 0/3 internal, 1 frame pulse, 2 target line |
| hs_width | input | 6 | Minimum line pulse length in ticks |
| vs_width | input | 6 | Minimum frame pulse length in ticks |
| hs_pol | input | 1 | Active level of line pulses |
| vs_pol | input | 1 | Active level of frame pulses |
| target_line | input | 11 | Line number that fires the trigger in mode 2 |
| xfer_en | input | 1 | Transfer enable from the pixel engine's control |
| frame_done | input | 1 | One-cycle pulse when the engine finishes a frame |
| start_trig | output | 1 | One-cycle start pulse for the transfer engine |
| cur_line | output | 11 | Lines counted since the last frame pulse |
| cfg_err | output | 1 | Pulse-width settings invalid for the selected mode |

## Verification
The assertions assume that the width, polarity and mode settings stay constant while a pulse is being measured. They also assume that `tick` marks the unit in which the widths are given. The stimulus therefore changes the configuration only while `te_in` rests at its inactive level, and it holds `tick` high, so that a run of N clocks is N ticks. Each pulse is followed by an idle gap longer than the synchronizer, classifier and counter pipeline, so every expected value is sampled once that pulse has fully settled. The polarity flip raises the pin before the active level is inverted, so that no stale run is classified under the new setting.

// File: rtl/te_sync_pkg.sv
// Shared types and the configuration legality check for the tearing-effect decoder.
// Assumes widths are given in ticks and are zero-extended by the caller.
package te_sync_pkg;

    typedef enum logic [1:0] {
        TRIG_INT   = 2'd0,
        TRIG_VSYNC = 2'd1,
        TRIG_LINE  = 2'd2,
        TRIG_RSV   = 2'd3
    } trig_mode_e;

    localparam int unsigned HS_MIN_TICKS       = 2;
    localparam int unsigned VS_MIN_TICKS_FRAME = 4;
    localparam int unsigned VS_MIN_TICKS_LINE  = 2;

    // Returns 1 when the widths cannot separate line and frame pulses in this mode.
    function automatic logic cfg_bad(input trig_mode_e mode,
                                     input int unsigned hs,
                                     input int unsigned vs);
        logic bad;
        bad = 1'b0;
        if (mode == TRIG_VSYNC || mode == TRIG_LINE) begin
            if (hs < HS_MIN_TICKS)
                bad = 1'b1;
            if (vs < ((mode == TRIG_VSYNC) ? VS_MIN_TICKS_FRAME : VS_MIN_TICKS_LINE))
                bad = 1'b1;
            if (hs == vs)
                bad = 1'b1;
        end
        return bad;
    endfunction

endpackage

// File: rtl/te_pulse_classifier.sv
// Synchronizes the shared tearing-effect pin, measures each run in ticks and,
// when a run ends, reports it as a line pulse or a frame pulse.
// Assumes widths and polarities are stable while a run is measured; the run
// that is in progress at reset is never classified.
module te_pulse_classifier #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             te_in,
    input  logic             hs_pol,
    input  logic             vs_pol,
    input  logic [CNT_W-1:0] hs_width,
    input  logic [CNT_W-1:0] vs_width,
    output logic             hs_evt,
    output logic             vs_evt
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic             sync1, sync2;
    logic             lvl_q;
    logic             run_ok;
    logic [CNT_W-1:0] run_len;
    logic             run_end, is_vs, is_hs;

    // Two-stage synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= te_in;
            sync2 <= sync1;
        end
    end

    // Decide the class of the run that ends in this cycle.
    always_comb begin
        run_end = (sync2 != lvl_q);
        is_vs   = run_ok && run_end && (lvl_q == vs_pol) && (run_len >= vs_width);
        is_hs   = run_ok && run_end && (lvl_q == hs_pol) && (run_len >= hs_width) && !is_vs;
    end

    // Track the current level and its length, saturating the length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            run_ok  <= 1'b0;
            run_len <= '0;
        end else if (run_end) begin
            lvl_q   <= sync2;
            run_ok  <= 1'b1;
            run_len <= tick ? CNT_W'(1) : '0;
        end else if (tick && run_len != RUN_MAX) begin
            run_len <= run_len + CNT_W'(1);
        end
    end

    // Register the classification as one-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_evt <= 1'b0;
            vs_evt <= 1'b0;
        end else begin
            hs_evt <= is_hs;
            vs_evt <= is_vs;
        end
    end

endmodule

// File: rtl/te_line_counter.sv
// Counts line pulses since the last frame pulse and strobes each update.
// Assumes at most one of hs_evt and vs_evt is high in a cycle.
module te_line_counter #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_evt,
    input  logic              vs_evt,
    output logic [LINE_W-1:0] cur_line,
    output logic              line_upd
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    // Clear on a frame pulse, step on a line pulse, hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line <= '0;
            line_upd <= 1'b0;
        end else if (vs_evt) begin
            cur_line <= '0;
            line_upd <= 1'b1;
        end else if (hs_evt) begin
            if (cur_line != LINE_MAX)
                cur_line <= cur_line + LINE_W'(1);
            line_upd <= 1'b1;
        end else begin
            line_upd <= 1'b0;
        end
    end

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_evt && vs_evt));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt |=> (cur_line == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_evt && !vs_evt && cur_line != LINE_MAX) |=> (cur_line == $past(cur_line) + LINE_W'(1)));

endmodule

// File: rtl/te_trigger_ctrl.sv
// Chooses the trigger source by mode and issues one start pulse per arming.
// Assumes frame_done is a single-cycle pulse from the transfer engine.
module te_trigger_ctrl
    import te_sync_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trig_mode_e        mode,
    input  logic              cfg_err,
    input  logic              xfer_en,
    input  logic              frame_done,
    input  logic              vs_evt,
    input  logic              line_upd,
    input  logic [LINE_W-1:0] cur_line,
    input  logic [LINE_W-1:0] target_line,
    output logic              start_trig
);
    logic issued;
    logic want, fire;

    // Pick the condition that would start a transfer in this mode.
    always_comb begin
        unique case (mode)
            TRIG_VSYNC: want = vs_evt && !cfg_err;
            TRIG_LINE:  want = line_upd && (cur_line == target_line) && !cfg_err;
            default:    want = 1'b1;
        endcase
        fire = xfer_en && !issued && want;
    end

    // Hold off further triggers until frame done or the enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued     <= 1'b0;
            start_trig <= 1'b0;
        end else begin
            start_trig <= fire;
            if (fire)
                issued <= 1'b1;
            else if (frame_done || !xfer_en)
                issued <= 1'b0;
        end
    end

    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_trig |=> !start_trig);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> !start_trig);

    p_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == TRIG_VSYNC || mode == TRIG_LINE) && cfg_err) |=> !start_trig);

endmodule

// File: rtl/te_sync_decoder.sv
// Top: decodes a shared tearing-effect pin into line and frame pulses, keeps
// the line count and triggers the pixel transfer engine.
// Assumes configuration changes only while the pin is idle.
module te_sync_decoder
    import te_sync_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              te_in,
    input  logic [1:0]        trig_mode,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic [CNT_W-1:0]  vs_width,
    input  logic              hs_pol,
    input  logic              vs_pol,
    input  logic [LINE_W-1:0] target_line,
    input  logic              xfer_en,
    input  logic              frame_done,
    output logic              start_trig,
    output logic [LINE_W-1:0] cur_line,
    output logic              cfg_err
);
    trig_mode_e mode;
    logic       hs_evt, vs_evt, line_upd;

    // Decode the mode and check the width settings against it.
    always_comb begin
        mode    = trig_mode_e'(trig_mode);
        cfg_err = cfg_bad(mode, 32'(hs_width), 32'(vs_width));
    end

    te_pulse_classifier #(.CNT_W(CNT_W)) u_class (
        .clk(clk), .rst_n(rst_n), .tick(tick), .te_in(te_in),
        .hs_pol(hs_pol), .vs_pol(vs_pol),
        .hs_width(hs_width), .vs_width(vs_width),
        .hs_evt(hs_evt), .vs_evt(vs_evt)
    );

    te_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .hs_evt(hs_evt), .vs_evt(vs_evt),
        .cur_line(cur_line), .line_upd(line_upd)
    );

    te_trigger_ctrl #(.LINE_W(LINE_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_err(cfg_err),
        .xfer_en(xfer_en), .frame_done(frame_done),
        .vs_evt(vs_evt), .line_upd(line_upd),
        .cur_line(cur_line), .target_line(target_line),
        .start_trig(start_trig)
    );

endmodule

// File: tb/te_sync_decoder_bench.sv
`timescale 1ns/1ps
// Bench: pulse-classification vectors from a table, then directed trigger tests.
module te_sync_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n, tick, te_in, hs_pol, vs_pol, xfer_en, frame_done;
    logic [1:0]  trig_mode;
    logic [5:0]  hs_width, vs_width;
    logic [10:0] target_line, cur_line;
    logic        start_trig, cfg_err;

    int total = 0, bad = 0, cyc = 0, trig_cnt = 0, last_trig = -1;
    int d_cyc = 0, base = 0, x = 0;
    bit done = 0;

    // Pulse length and expected line count afterwards (hs=3, vs=6, active high).
    localparam logic [18:0] VEC [8] = '{
        {8'd6, 11'd0}, {8'd3, 11'd1}, {8'd2, 11'd1}, {8'd5, 11'd2},
        {8'd3, 11'd3}, {8'd8, 11'd0}, {8'd1, 11'd0}, {8'd4, 11'd1}
    };

    always #2 clk = ~clk;

    te_sync_decoder u_te_sync_decoder (
        .clk(clk), .rst_n(rst_n), .tick(tick), .te_in(te_in),
        .trig_mode(trig_mode), .hs_width(hs_width), .vs_width(vs_width),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .target_line(target_line),
        .xfer_en(xfer_en), .frame_done(frame_done),
        .start_trig(start_trig), .cur_line(cur_line), .cfg_err(cfg_err)
    );

    // Cycle count and trigger monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (start_trig) begin
            trig_cnt  <= trig_cnt + 1;
            last_trig <= cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Active run of len clocks at level lvl, then back to ~lvl and settle.
    task automatic te_pulse(input logic lvl, input int len);
        @(negedge clk);
        te_in = lvl;
        repeat (len) @(negedge clk);
        te_in = ~lvl;
        d_cyc = cyc;
        repeat (8) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        frame_done = 1'b1;
        x = cyc;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tick = 1; te_in = 0; hs_pol = 1; vs_pol = 1;
        xfer_en = 0; frame_done = 0; trig_mode = 2'd0;
        hs_width = 6'd3; vs_width = 6'd6; target_line = '0;
        idle(4);
        rst_n = 1;
        idle(2);
        check("R1 start_trig", int'(start_trig), 0);
        check("R1 cur_line", int'(cur_line), 0);
        check("R1 cfg_err", int'(cfg_err), 0);

        // R3/R4: classification vectors walked by one loop.
        for (int i = 0; i < 8; i++) begin
            te_pulse(1'b1, int'(VEC[i][18:11]));
            check($sformatf("R3 R4 vector %0d", i), int'(cur_line), int'(VEC[i][10:0]));
        end
        check("R10 no trigger while disabled", trig_cnt, 0);

        // R2 internal mode, R8 re-arm on frame_done and on enable drop.
        @(negedge clk);
        xfer_en = 1'b1;
        x = cyc;
        idle(10);
        check("R2 internal count", trig_cnt, 1);
        check("R2 internal timing", last_trig, x + 1);
        done_pulse();
        idle(10);
        check("R8 rearm count", trig_cnt, 2);
        check("R8 rearm timing", last_trig, x + 2);
        @(negedge clk);
        xfer_en = 1'b0;
        idle(10);
        check("R10 idle", trig_cnt, 2);
        @(negedge clk);
        trig_mode = 2'd3;
        xfer_en = 1'b1;
        x = cyc;
        idle(10);
        check("R2 mode3 count", trig_cnt, 3);
        check("R2 mode3 timing", last_trig, x + 1);
        @(negedge clk);
        xfer_en = 1'b0;

        // R6 frame mode.
        @(negedge clk);
        trig_mode = 2'd1;
        xfer_en = 1'b1;
        base = trig_cnt;
        te_pulse(1'b1, 3);
        check("R6 line pulse no trigger", trig_cnt, base);
        te_pulse(1'b1, 6);
        check("R6 frame count", trig_cnt, base + 1);
        check("R6 frame timing", last_trig, d_cyc + 4);
        te_pulse(1'b1, 7);
        check("R8 one per enable", trig_cnt, base + 1);
        done_pulse();
        te_pulse(1'b1, 6);
        check("R8 after done", trig_cnt, base + 2);
        check("R6 timing after done", last_trig, d_cyc + 4);
        @(negedge clk);
        xfer_en = 1'b0;

        // R7 line mode.
        @(negedge clk);
        trig_mode = 2'd2;
        target_line = 11'd2;
        xfer_en = 1'b1;
        base = trig_cnt;
        te_pulse(1'b1, 6);
        te_pulse(1'b1, 3);
        check("R7 before target", trig_cnt, base);
        te_pulse(1'b1, 3);
        check("R7 line reached", trig_cnt, base + 1);
        check("R7 line timing", last_trig, d_cyc + 5);
        check("R4 line value", int'(cur_line), 2);
        @(negedge clk);
        xfer_en = 1'b0;
        target_line = 11'd2;
        @(negedge clk);
        xfer_en = 1'b1;
        idle(10);
        check("R7 equal at enable no trigger", trig_cnt, base + 1);
        @(negedge clk);
        xfer_en = 1'b0;
        target_line = 11'd0;
        @(negedge clk);
        xfer_en = 1'b1;
        te_pulse(1'b1, 6);
        check("R7 target zero", trig_cnt, base + 2);
        check("R7 target zero timing", last_trig, d_cyc + 5);
        @(negedge clk);
        xfer_en = 1'b0;

        // R9 configuration check.
        @(negedge clk);
        trig_mode = 2'd1; hs_width = 6'd3; vs_width = 6'd3;
        @(negedge clk);
        check("R9 equal widths", int'(cfg_err), 1);
        hs_width = 6'd1; vs_width = 6'd6;
        @(negedge clk);
        check("R9 short line width", int'(cfg_err), 1);
        hs_width = 6'd2; vs_width = 6'd3;
        @(negedge clk);
        check("R9 mode1 frame min", int'(cfg_err), 1);
        trig_mode = 2'd2;
        @(negedge clk);
        check("R9 mode2 frame min", int'(cfg_err), 0);
        trig_mode = 2'd0; hs_width = 6'd3; vs_width = 6'd3;
        @(negedge clk);
        check("R9 internal ignores widths", int'(cfg_err), 0);
        trig_mode = 2'd1;
        xfer_en = 1'b1;
        base = trig_cnt;
        te_pulse(1'b1, 6);
        check("R9 no trigger on error", trig_cnt, base);
        @(negedge clk);
        xfer_en = 1'b0;
        trig_mode = 2'd0; hs_width = 6'd3; vs_width = 6'd6;

        // R5 active-low pulses.
        te_pulse(1'b1, 6);
        @(negedge clk);
        te_in = 1'b1;
        idle(8);
        hs_pol = 1'b0; vs_pol = 1'b0;
        idle(2);
        check("R5 idle high no count", int'(cur_line), 0);
        te_pulse(1'b0, 3);
        te_pulse(1'b0, 4);
        check("R5 low line pulses", int'(cur_line), 2);
        te_pulse(1'b0, 6);
        check("R5 low frame pulse", int'(cur_line), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule